// File: doc/BRIEF.md
# Performance Monitoring Counter Unit

This block counts hardware events for one processor core. It has four programmable counters and three fixed-function counters, all 48 bits wide. Each programmable counter has an event-select register. That register names an event by an 8-bit code and an 8-bit unit mask. In each cycle the counter adds the number of event lanes whose code and mask both match. The three fixed counters count three dedicated pulses: retired instructions, core cycles and reference cycles.

Counting is gated at two levels. A global enable register turns each counter on or off. A per-counter privilege qualifier then checks the level at which the core is running. Software reaches the registers through a plain write/read port addressed by register number. A separate counter-read port takes a counter index and returns that counter's value. On this port, index bit 30 chooses between the programmable bank and the fixed bank.

The counter-read port follows valid/ready rules. A request is accepted on a clock edge where `rd_req_valid` and `rd_req_ready` are both high. The response appears on the next cycle and is held unchanged while `rd_rsp_ready` is low. `rd_req_ready` is high when no response is pending, or when the pending response is being taken in the same cycle.

Top module: `pmu_unit`

## Requirements
- R1: After reset every register and counter reads zero, `irq` is low, `rd_rsp_valid` is low and `rd_req_ready` is high.
- R2: A programmable counter n adds, in each cycle, the number of valid event lanes whose code equals its event-select bits 7:0 and whose unit mask equals bits 15:8. A lane that matches only one of the two fields is not counted.
- R3: A programmable counter n counts only when all of the following hold: global bit n is set, event-select bit 22 is set, and the privilege qualifier matches. The qualifier is bit 16 when `priv` is nonzero (user level) and bit 17 when `priv` is zero (kernel level).
- R4: Fixed counter n adds one per cycle when all of the following hold: `fix_evt[n]` is high, global bit 32+n is set, and the matching bit of its 4-bit field in the fixed-control register is set. The field sits at bits 4n+3:4n. Field bit 0 qualifies kernel level (`priv` zero) and field bit 1 qualifies user level.
- R5: Register map: 0 global control, 1 fixed control, 2 overflow status, 4..7 event selects, 8..11 programmable counters, 12..14 fixed counters. Reserved bits read zero and ignore writes; this includes bit 2 of each fixed field and every event-select bit other than 15:0, 16, 17, 20 and 22. Unmapped addresses read zero.
- R6: A register write to a counter in the same cycle as an increment stores the written value, and the increment is lost.
- R7: When a counter carries past all ones, its overflow status bit sets. The bit is at position n for programmable counters and at 32+n for fixed counters. It stays set until software writes a one to it at address 2.
- R8: A wrap pulses `irq` high for one cycle when the wrapping counter's interrupt enable is set. For a programmable counter this is event-select bit 20; for a fixed counter it is field bit 3.
- R9: On the read port, index bit 30 clear returns programmable counter idx[29:0]. Index bit 30 set returns fixed counter idx[29:0]: 0x40000000 is retired instructions, +1 is core cycles, +2 is reference cycles.
- R10: An index whose number is out of range, or whose bit 31 is set, returns data zero with `rd_rsp_err` high for that response.
- R11: While `rd_rsp_valid` is high and `rd_rsp_ready` is low, the response holds its data and error, and `rd_req_ready` is low.
- R12: Counter registers read back 48 bits, and bits 63:48 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register number for both write and read |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Register read data for `csr_addr` (combinational) |
| priv | input | 2 | Current privilege level; 0 is kernel, nonzero is user |
| evt_valid | input | 2 | Per-lane event pulse |
| evt_code | input | 16 | Per-lane event code, lane 0 in bits 7:0 |
| evt_umask | input | 16 | Per-lane unit mask, lane 0 in bits 7:0 |
| fix_evt | input | 3 | Fixed event pulses: retired instruction, core cycle, reference cycle |
| irq | output | 1 | One-cycle overflow interrupt pulse |
| rd_req_valid | input | 1 | Counter read request valid |
| rd_req_ready | output | 1 | Counter read request ready |
| rd_req_idx | input | 32 | Counter index; bit 30 selects the fixed bank |
| rd_rsp_valid | output | 1 | Counter read response valid |
| rd_rsp_ready | input | 1 | Counter read response ready |
| rd_rsp_data | output | 48 | Counter value |
| rd_rsp_err | output | 1 | Index out of range |

## Verification
A wrong match or a wrong gate decision in a counter shows at the counter's register one cycle after the event cycle. The sweeps read the register back after every single event cycle, so the first mis-gated combination is reported on its own. A faulty carry or overflow path shows at the same edge in three places: the counter reading zero, the status bit, and the `irq` pulse. A fault in read-port decode or hold shows in the response one cycle after acceptance, or in any later cycle of a stall.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int unsigned REG_W       = 64;
  localparam int unsigned ADDR_W      = 5;
  localparam int unsigned IDX_W       = 32;
  localparam int unsigned CODE_W      = 8;

  localparam int unsigned RA_GCTL     = 0;
  localparam int unsigned RA_FCTL     = 1;
  localparam int unsigned RA_OVF      = 2;
  localparam int unsigned RA_EVS      = 4;

  localparam int unsigned EVS_USR     = 16;
  localparam int unsigned EVS_KRN     = 17;
  localparam int unsigned EVS_INT     = 20;
  localparam int unsigned EVS_EN      = 22;
  localparam logic [REG_W-1:0] EVS_MASK = 64'h0000_0000_0053_FFFF;

  localparam int unsigned FIX_GBIT    = 32;
  localparam int unsigned FLD_W       = 4;
  localparam int unsigned FLD_KRN     = 0;
  localparam int unsigned FLD_USR     = 1;
  localparam int unsigned FLD_INT     = 3;
  localparam logic [FLD_W-1:0] FLD_MASK = 4'b1011;

  localparam int unsigned IDX_FIX_BIT = 30;
  localparam int unsigned IDX_BAD_BIT = 31;
endpackage

// File: rtl/pmu_evt_match.sv
module pmu_evt_match
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_LANES = 2,
  parameter int unsigned INC_W     = $clog2(NUM_LANES + 1)
) (
  input  logic [REG_W-1:0]            evsel_i,
  input  logic                        gbl_en_i,
  input  logic                        priv_user_i,
  input  logic [NUM_LANES-1:0]        lane_vld_i,
  input  logic [NUM_LANES*CODE_W-1:0] lane_code_i,
  input  logic [NUM_LANES*CODE_W-1:0] lane_umask_i,
  output logic [INC_W-1:0]            inc_o
);
  logic [NUM_LANES-1:0] hit;
  logic [INC_W-1:0]     hit_cnt;
  logic                 gate;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign hit[l] = lane_vld_i[l]
                 && (lane_code_i[l*CODE_W +: CODE_W]  == evsel_i[CODE_W-1:0])
                 && (lane_umask_i[l*CODE_W +: CODE_W] == evsel_i[2*CODE_W-1:CODE_W]);
  end

  always_comb begin
    hit_cnt = '0;
    for (int l = 0; l < NUM_LANES; l++) begin
      hit_cnt = hit_cnt + INC_W'(hit[l]);
    end
  end

  assign gate  = gbl_en_i && evsel_i[EVS_EN]
              && (priv_user_i ? evsel_i[EVS_USR] : evsel_i[EVS_KRN]);
  assign inc_o = gate ? hit_cnt : '0;
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int unsigned CNT_W = 48,
  parameter int unsigned INC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  assign sum    = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);
  assign wrap_o = sum[CNT_W] && !wr_en_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (wr_en_i) cnt_q <= wr_val_i;
    else              cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/pmu_read_port.sv
module pmu_read_port
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_PROG = 4,
  parameter int unsigned NUM_FIX  = 3,
  parameter int unsigned CNT_W    = 48
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [IDX_W-1:0]          req_idx_i,
  input  logic [NUM_PROG*CNT_W-1:0] pcnt_i,
  input  logic [NUM_FIX*CNT_W-1:0]  fcnt_i,
  output logic                      rsp_valid_o,
  input  logic                      rsp_ready_i,
  output logic [CNT_W-1:0]          rsp_data_o,
  output logic                      rsp_err_o
);
  localparam int unsigned NUM_W = IDX_FIX_BIT;

  logic [NUM_W-1:0] num;
  logic             sel_fix;
  logic             bad;
  logic [CNT_W-1:0] sel_data;
  logic             accept;
  logic             vld_q, err_q;
  logic [CNT_W-1:0] data_q;

  assign num     = req_idx_i[NUM_W-1:0];
  assign sel_fix = req_idx_i[IDX_FIX_BIT];

  always_comb begin
    bad      = 1'b1;
    sel_data = '0;
    if (!req_idx_i[IDX_BAD_BIT]) begin
      for (int p = 0; p < NUM_PROG; p++) begin
        if (!sel_fix && num == NUM_W'(p)) begin
          sel_data = pcnt_i[p*CNT_W +: CNT_W];
          bad      = 1'b0;
        end
      end
      for (int f = 0; f < NUM_FIX; f++) begin
        if (sel_fix && num == NUM_W'(f)) begin
          sel_data = fcnt_i[f*CNT_W +: CNT_W];
          bad      = 1'b0;
        end
      end
    end
  end

  assign req_ready_o = !vld_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      err_q  <= bad;
      data_q <= sel_data;
    end else if (rsp_ready_i) begin
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_data_o  = data_q;
  assign rsp_err_o   = err_q;
endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
  import pmu_pkg::*;
#(
  parameter int unsigned NUM_PROG  = 4,
  parameter int unsigned NUM_FIX   = 3,
  parameter int unsigned CNT_W     = 48,
  parameter int unsigned NUM_LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic [ADDR_W-1:0]           csr_addr,
  input  logic [REG_W-1:0]            csr_wdata,
  output logic [REG_W-1:0]            csr_rdata,
  input  logic [1:0]                  priv,
  input  logic [NUM_LANES-1:0]        evt_valid,
  input  logic [NUM_LANES*CODE_W-1:0] evt_code,
  input  logic [NUM_LANES*CODE_W-1:0] evt_umask,
  input  logic [NUM_FIX-1:0]          fix_evt,
  output logic                        irq,
  input  logic                        rd_req_valid,
  output logic                        rd_req_ready,
  input  logic [IDX_W-1:0]            rd_req_idx,
  output logic                        rd_rsp_valid,
  input  logic                        rd_rsp_ready,
  output logic [CNT_W-1:0]            rd_rsp_data,
  output logic                        rd_rsp_err
);
  localparam int unsigned INC_W   = $clog2(NUM_LANES + 1);
  localparam int unsigned RA_PCNT = RA_EVS + NUM_PROG;
  localparam int unsigned RA_FCNT = RA_PCNT + NUM_PROG;

  function automatic logic [REG_W-1:0] gbl_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    for (int p = 0; p < NUM_PROG; p++) m[p] = 1'b1;
    for (int f = 0; f < NUM_FIX; f++)  m[FIX_GBIT + f] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] fctl_mask_f();
    logic [REG_W-1:0] m;
    m = '0;
    for (int f = 0; f < NUM_FIX; f++) m[f*FLD_W +: FLD_W] = FLD_MASK;
    return m;
  endfunction

  localparam logic [REG_W-1:0] GBL_MASK  = gbl_mask_f();
  localparam logic [REG_W-1:0] FCTL_MASK = fctl_mask_f();

  logic [REG_W-1:0]          gctl_q, fctl_q, ovf_q;
  logic [REG_W-1:0]          evsel_q [NUM_PROG];
  logic                      irq_q;
  logic                      priv_user;
  logic [NUM_PROG*CNT_W-1:0] pcnt_flat;
  logic [NUM_FIX*CNT_W-1:0]  fcnt_flat;
  logic [NUM_PROG-1:0]       pwrap;
  logic [NUM_FIX-1:0]        fwrap;
  logic [REG_W-1:0]          ovf_set, ovf_clr, int_en;

  assign priv_user = (priv != 2'd0);

  // control and event-select registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gctl_q <= '0;
      fctl_q <= '0;
    end else if (csr_we) begin
      if (csr_addr == ADDR_W'(RA_GCTL)) gctl_q <= csr_wdata & GBL_MASK;
      if (csr_addr == ADDR_W'(RA_FCTL)) fctl_q <= csr_wdata & FCTL_MASK;
    end
  end

  for (genvar p = 0; p < NUM_PROG; p++) begin : g_evs
    always_ff @(posedge clk) begin
      if (!rst_n)
        evsel_q[p] <= '0;
      else if (csr_we && csr_addr == ADDR_W'(RA_EVS + p))
        evsel_q[p] <= csr_wdata & EVS_MASK;
    end
  end

  // programmable counters
  for (genvar p = 0; p < NUM_PROG; p++) begin : g_prog
    logic [INC_W-1:0] inc;
    pmu_evt_match #(.NUM_LANES(NUM_LANES), .INC_W(INC_W)) u_match (
      .evsel_i      (evsel_q[p]),
      .gbl_en_i     (gctl_q[p]),
      .priv_user_i  (priv_user),
      .lane_vld_i   (evt_valid),
      .lane_code_i  (evt_code),
      .lane_umask_i (evt_umask),
      .inc_o        (inc)
    );
    pmu_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (csr_we && csr_addr == ADDR_W'(RA_PCNT + p)),
      .wr_val_i (csr_wdata[CNT_W-1:0]),
      .inc_i    (inc),
      .cnt_o    (pcnt_flat[p*CNT_W +: CNT_W]),
      .wrap_o   (pwrap[p])
    );
  end

  // fixed counters
  for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix
    logic inc;
    assign inc = fix_evt[f] && gctl_q[FIX_GBIT + f]
              && (priv_user ? fctl_q[f*FLD_W + FLD_USR] : fctl_q[f*FLD_W + FLD_KRN]);
    pmu_counter #(.CNT_W(CNT_W), .INC_W(1)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (csr_we && csr_addr == ADDR_W'(RA_FCNT + f)),
      .wr_val_i (csr_wdata[CNT_W-1:0]),
      .inc_i    (inc),
      .cnt_o    (fcnt_flat[f*CNT_W +: CNT_W]),
      .wrap_o   (fwrap[f])
    );
  end

  // overflow status and interrupt
  always_comb begin
    ovf_set = '0;
    int_en  = '0;
    for (int p = 0; p < NUM_PROG; p++) begin
      ovf_set[p] = pwrap[p];
      int_en[p]  = evsel_q[p][EVS_INT];
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      ovf_set[FIX_GBIT + f] = fwrap[f];
      int_en[FIX_GBIT + f]  = fctl_q[f*FLD_W + FLD_INT];
    end
    ovf_clr = (csr_we && csr_addr == ADDR_W'(RA_OVF)) ? (csr_wdata & GBL_MASK) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= '0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
      irq_q <= |(ovf_set & int_en);
    end
  end
  assign irq = irq_q;

  // register read mux
  always_comb begin
    csr_rdata = '0;
    if (csr_addr == ADDR_W'(RA_GCTL)) csr_rdata = gctl_q;
    if (csr_addr == ADDR_W'(RA_FCTL)) csr_rdata = fctl_q;
    if (csr_addr == ADDR_W'(RA_OVF))  csr_rdata = ovf_q;
    for (int p = 0; p < NUM_PROG; p++) begin
      if (csr_addr == ADDR_W'(RA_EVS + p))  csr_rdata = evsel_q[p];
      if (csr_addr == ADDR_W'(RA_PCNT + p)) csr_rdata = REG_W'(pcnt_flat[p*CNT_W +: CNT_W]);
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      if (csr_addr == ADDR_W'(RA_FCNT + f)) csr_rdata = REG_W'(fcnt_flat[f*CNT_W +: CNT_W]);
    end
  end

  pmu_read_port #(.NUM_PROG(NUM_PROG), .NUM_FIX(NUM_FIX), .CNT_W(CNT_W)) u_rdp (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (rd_req_valid),
    .req_ready_o (rd_req_ready),
    .req_idx_i   (rd_req_idx),
    .pcnt_i      (pcnt_flat),
    .fcnt_i      (fcnt_flat),
    .rsp_valid_o (rd_rsp_valid),
    .rsp_ready_i (rd_rsp_ready),
    .rsp_data_o  (rd_rsp_data),
    .rsp_err_o   (rd_rsp_err)
  );
endmodule

// File: rtl/pmu_unit_chk.sv
module pmu_unit_chk
  import pmu_pkg::*;
#(
  parameter int unsigned CNT_W     = 48,
  parameter int unsigned PCNT_ADDR = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [REG_W-1:0]  csr_wdata,
  input logic [CNT_W-1:0]  pcnt0,
  input logic              gctl0,
  input logic              ovf0,
  input logic              ovf_any,
  input logic              irq,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [CNT_W-1:0]  rsp_data,
  input logic              rsp_err
);
  logic wr_cnt0, clr_ovf0;
  assign wr_cnt0  = csr_we && csr_addr == ADDR_W'(PCNT_ADDR);
  assign clr_ovf0 = csr_we && csr_addr == ADDR_W'(RA_OVF) && csr_wdata[0];

  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gctl0 && !wr_cnt0) |=> $stable(pcnt0));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt0 |=> (pcnt0 == $past(csr_wdata[CNT_W-1:0])));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0 && !clr_ovf0) |=> ovf0);

  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf_any);

  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
endmodule

bind pmu_unit pmu_unit_chk #(.CNT_W(CNT_W), .PCNT_ADDR(RA_PCNT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csr_we    (csr_we),
  .csr_addr  (csr_addr),
  .csr_wdata (csr_wdata),
  .pcnt0     (pcnt_flat[CNT_W-1:0]),
  .gctl0     (gctl_q[0]),
  .ovf0      (ovf_q[0]),
  .ovf_any   (|ovf_q),
  .irq       (irq),
  .rsp_valid (rd_rsp_valid),
  .rsp_ready (rd_rsp_ready),
  .rsp_data  (rd_rsp_data),
  .rsp_err   (rd_rsp_err)
);

// File: tb/test_pmu_unit.sv
`timescale 1ns/1ps
module test_pmu_unit;
  localparam int NL = 2;
  localparam int CW = 48;
  localparam logic [63:0] CMAX = (64'd1 << CW) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_addr = '0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic [1:0]  priv = '0;
  logic [NL-1:0]   evt_valid = '0;
  logic [NL*8-1:0] evt_code = '0;
  logic [NL*8-1:0] evt_umask = '0;
  logic [2:0]  fix_evt = '0;
  logic        irq;
  logic        rd_req_valid = 1'b0;
  logic        rd_req_ready;
  logic [31:0] rd_req_idx = '0;
  logic        rd_rsp_valid;
  logic        rd_rsp_ready = 1'b1;
  logic [CW-1:0] rd_rsp_data;
  logic        rd_rsp_err;

  int n_vec = 0;
  int n_bad = 0;

  pmu_unit i_pmu_unit (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .priv(priv),
    .evt_valid(evt_valid), .evt_code(evt_code), .evt_umask(evt_umask),
    .fix_evt(fix_evt), .irq(irq), .rd_req_valid(rd_req_valid),
    .rd_req_ready(rd_req_ready), .rd_req_idx(rd_req_idx),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err)
  );

  always #2 clk = ~clk;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    finish_run();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input int a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = 5'(a); csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input int a, output logic [63:0] d);
    csr_addr = 5'(a);
    #1;
    d = csr_rdata;
  endtask

  function automatic logic [7:0] pr_code(input int i);
    case (i)
      0: return 8'h2E; 1: return 8'h2E; 2: return 8'h2F;
      3: return 8'h2E; 4: return 8'h41; default: return 8'h2F;
    endcase
  endfunction

  function automatic logic [7:0] pr_mask(input int i);
    case (i)
      0: return 8'h41; 1: return 8'h4F; 2: return 8'h41;
      3: return 8'h40; 4: return 8'h2E; default: return 8'h4F;
    endcase
  endfunction

  task automatic set_lane(input int l, input int sel);
    evt_valid[l] = (sel < 6);
    evt_code[l*8 +: 8]  = (sel < 6) ? pr_code(sel) : 8'h00;
    evt_umask[l*8 +: 8] = (sel < 6) ? pr_mask(sel) : 8'h00;
  endtask

  task automatic clr_lanes();
    evt_valid = '0; evt_code = '0; evt_umask = '0;
  endtask

  logic [63:0] pval [4];
  logic [63:0] fval [3];

  task automatic rd_expect(input logic [31:0] idx, output logic [63:0] d, output logic e);
    int unsigned n;
    n = idx[29:0];
    d = 0; e = 1'b1;
    if (!idx[31]) begin
      if (!idx[30] && n < 4) begin d = pval[n]; e = 1'b0; end
      if (idx[30] && n < 3)  begin d = fval[n]; e = 1'b0; end
    end
  endtask

  logic [63:0] rv;
  logic [63:0] e0, e1, exp_d;
  logic exp_e;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      csr_rd(a, rv);
      chk($sformatf("R1 reg %0d after reset", a), rv, 64'd0);
    end
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    chk("R1 rsp_valid after reset", {63'd0, rd_rsp_valid}, 64'd0);
    chk("R1 req_ready after reset", {63'd0, rd_req_ready}, 64'd1);

    // R5 reserved bits, R12 counter width
    csr_wr(0, '1); csr_rd(0, rv); chk("R5 global mask", rv, 64'h0000_0007_0000_000F);
    csr_wr(0, 0);
    csr_wr(1, '1); csr_rd(1, rv); chk("R5 fixed ctrl mask", rv, 64'h0000_0000_0000_0BBB);
    csr_wr(1, 0);
    csr_wr(4, '1); csr_rd(4, rv); chk("R5 event select mask", rv, 64'h0000_0000_0053_FFFF);
    csr_wr(4, 0);
    csr_wr(3, '1);  csr_rd(3, rv);  chk("R5 unmapped 3", rv, 64'd0);
    csr_wr(20, '1); csr_rd(20, rv); chk("R5 unmapped 20", rv, 64'd0);
    csr_wr(8, '1);  csr_rd(8, rv);  chk("R12 counter width", rv, CMAX);
    csr_wr(8, 0);

    // R2 match sweep over lane pairs
    csr_wr(0, 64'hF);
    csr_wr(4, 64'h43412E);
    csr_wr(5, 64'h434F2E);
    priv = 2'd3;
    e0 = 0; e1 = 0;
    for (int a = 0; a < 7; a++) begin
      for (int b = 0; b < 7; b++) begin
        @(negedge clk);
        set_lane(0, a); set_lane(1, b);
        @(negedge clk);
        clr_lanes();
        e0 = e0 + ((a == 0) ? 1 : 0) + ((b == 0) ? 1 : 0);
        e1 = e1 + ((a == 1) ? 1 : 0) + ((b == 1) ? 1 : 0);
        csr_rd(8, rv); chk($sformatf("R2 ctr0 lanes %0d/%0d", a, b), rv, e0);
        csr_rd(9, rv); chk($sformatf("R2 ctr1 lanes %0d/%0d", a, b), rv, e1);
      end
    end

    // R3 gating sweep on counter 2
    for (int g = 0; g < 2; g++)
      for (int en = 0; en < 2; en++)
        for (int us = 0; us < 2; us++)
          for (int kr = 0; kr < 2; kr++)
            for (int pv = 0; pv < 4; pv++) begin
              csr_wr(0, 64'(g) << 2);
              csr_wr(6, (64'(en) << 22) | (64'(us) << 16) | (64'(kr) << 17) | 64'h3F24);
              csr_wr(10, 0);
              @(negedge clk);
              priv = 2'(pv);
              evt_valid[0] = 1'b1; evt_code[7:0] = 8'h24; evt_umask[7:0] = 8'h3F;
              @(negedge clk);
              clr_lanes();
              csr_rd(10, rv);
              chk($sformatf("R3 g%0d en%0d u%0d k%0d p%0d", g, en, us, kr, pv), rv,
                  64'((g & en & ((pv != 0) ? us : kr))));
            end

    // R4 fixed counter gating sweep
    for (int n = 0; n < 3; n++)
      for (int g = 0; g < 2; g++)
        for (int f = 0; f < 4; f++)
          for (int pv = 0; pv < 4; pv++) begin
            csr_wr(0, 64'(g) << (32 + n));
            csr_wr(1, 64'(f) << (4 * n));
            csr_wr(12 + n, 0);
            @(negedge clk);
            priv = 2'(pv);
            fix_evt = 3'b111;
            repeat (3) @(negedge clk);
            fix_evt = 3'b000;
            csr_rd(12 + n, rv);
            chk($sformatf("R4 fix%0d g%0d f%0d p%0d", n, g, f, pv), rv,
                64'(3 * (g & ((pv == 0) ? (f & 1) : ((f >> 1) & 1)))));
          end

    // R6 write beats increment
    csr_wr(0, 64'h1);
    csr_wr(4, 64'h43412E);
    csr_wr(8, 5);
    @(negedge clk);
    set_lane(0, 0); set_lane(1, 0);
    csr_we = 1'b1; csr_addr = 5'd8; csr_wdata = 64'd100;
    @(negedge clk);
    csr_we = 1'b0;
    clr_lanes();
    csr_rd(8, rv); chk("R6 write wins over increment", rv, 64'd100);
    @(negedge clk);
    set_lane(0, 0); set_lane(1, 0);
    @(negedge clk);
    clr_lanes();
    csr_rd(8, rv); chk("R6 counting resumes", rv, 64'd102);

    // R7 R8 programmable wrap with interrupt
    csr_wr(4, 64'h53412E);
    csr_wr(8, CMAX - 1);
    @(negedge clk);
    set_lane(0, 0); set_lane(1, 0);
    @(negedge clk);
    clr_lanes();
    chk("R8 irq on wrap", {63'd0, irq}, 64'd1);
    csr_rd(8, rv); chk("R7 counter wrapped to zero", rv, 64'd0);
    csr_rd(2, rv); chk("R7 overflow bit 0 set", rv, 64'd1);
    @(negedge clk);
    chk("R8 irq single cycle", {63'd0, irq}, 64'd0);
    csr_rd(2, rv); chk("R7 overflow sticky", rv, 64'd1);
    csr_wr(2, 64'd1);
    csr_rd(2, rv); chk("R7 overflow cleared", rv, 64'd0);

    // R7 R8 fixed wrap without and with interrupt
    csr_wr(0, 64'h4_0000_0000);
    for (int ie = 0; ie < 2; ie++) begin
      csr_wr(1, ie ? 64'hB00 : 64'h300);
      csr_wr(14, CMAX);
      @(negedge clk);
      priv = 2'd0;
      fix_evt = 3'b100;
      @(negedge clk);
      fix_evt = 3'b000;
      chk($sformatf("R8 fixed irq ie=%0d", ie), {63'd0, irq}, 64'(ie));
      csr_rd(14, rv); chk("R7 fixed wrapped", rv, 64'd0);
      csr_rd(2, rv);  chk("R7 fixed overflow bit 34", rv, 64'h4_0000_0000);
      csr_wr(2, 64'h4_0000_0000);
    end

    // R9 R10 read port sweep
    csr_wr(0, 0);
    csr_wr(1, 0);
    for (int p = 0; p < 4; p++) begin
      pval[p] = 64'h1000 + 64'(p);
      csr_wr(8 + p, pval[p]);
    end
    for (int f = 0; f < 3; f++) begin
      fval[f] = 64'hA000_0000_0000 + 64'(f);
      csr_wr(12 + f, fval[f]);
    end
    for (int k = 0; k < 12; k++) begin
      logic [31:0] idx;
      case (k)
        0: idx = 32'd0;  1: idx = 32'd1;  2: idx = 32'd2;  3: idx = 32'd3;
        4: idx = 32'd4;  5: idx = 32'd5;
        6: idx = 32'h4000_0000; 7: idx = 32'h4000_0001; 8: idx = 32'h4000_0002;
        9: idx = 32'h4000_0003; 10: idx = 32'h8000_0000; default: idx = 32'hC000_0001;
      endcase
      rd_expect(idx, exp_d, exp_e);
      @(negedge clk);
      rd_req_valid = 1'b1; rd_req_idx = idx;
      @(negedge clk);
      rd_req_valid = 1'b0;
      chk($sformatf("R9 valid idx 0x%0h", idx), {63'd0, rd_rsp_valid}, 64'd1);
      chk($sformatf("R9 data idx 0x%0h", idx), 64'(rd_rsp_data), exp_d);
      chk($sformatf("R10 err idx 0x%0h", idx), {63'd0, rd_rsp_err}, 64'(exp_e));
    end
    @(negedge clk);
    chk("R11 response drained", {63'd0, rd_rsp_valid}, 64'd0);

    // R11 back-pressure
    rd_rsp_ready = 1'b0;
    rd_req_valid = 1'b1; rd_req_idx = 32'd1;
    @(negedge clk);
    rd_req_idx = 32'd2;
    for (int s = 0; s < 3; s++) begin
      chk("R11 held valid", {63'd0, rd_rsp_valid}, 64'd1);
      chk("R11 held data", 64'(rd_rsp_data), 64'h1001);
      chk("R11 ready low while stalled", {63'd0, rd_req_ready}, 64'd0);
      @(negedge clk);
    end
    rd_rsp_ready = 1'b1;
    @(negedge clk);
    rd_req_valid = 1'b0;
    chk("R11 next response after release", 64'(rd_rsp_data), 64'h1002);
    chk("R11 next response valid", {63'd0, rd_rsp_valid}, 64'd1);
    @(negedge clk);
    chk("R11 idle after drain", {63'd0, rd_rsp_valid}, 64'd0);

    finish_run();
  end
endmodule